// File: doc/BRIEF.md
# Prescaled Sixteen-Bit Base Timer

This block is the shared time base for a group of capture and compare channels. It is a 16-bit counter that only counts up. It advances once per tick of a programmable prescaler. The prescaler divides the system clock by twice the selected value plus two, or passes the clock through undivided when the selector is at its top code.

The counter can be started in two ways. The first is a local run bit. The second is a pair of group run bits: one belongs to this timer and one to a neighbouring timer group, and when both are set the two groups start together. While the timer is stopped it is held at zero. A 2-bit clear-source selector picks what returns the count to zero while it runs:
- plain wrap past FFFFh,
- a match against a compare value,
- a clear request from the neighbouring group,
- a clear request from a communication block.

Software can load a new count while the timer runs. Whenever bit 14 or bit 15 of the count falls from 1 to 0, the block raises a one-cycle pulse and a sticky request flag.

Top module: `bt_timebase`

## Requirements
- R1: With `div_sel` = n in 0..30, the count advances once every 2(n+1) clock cycles. With n = 31 it advances every cycle. The first increment after a start lands exactly one period after the timer becomes active. The timer becomes active one edge after the start condition is driven.
- R2: After `rst`, and at all times while the timer is stopped, `rd_data` reads 0000h. After `rst`, `irq_flag` and `irq_pulse` are 0.
- R3: Driving `run_local` to 1 starts a stopped timer on the next clock edge.
- R4: A stopped timer also starts when `run_grp_self` and `run_grp_peer` are both 1. Either of the two alone, with `run_local` at 0, does not start it.
- R5: A running timer stops, and its count returns to 0000h on the next edge, only when `run_local` and `run_grp_self` are both 0. Clearing `run_grp_peer` alone has no effect on a running timer.
- R6: With `clr_sel` = 2'b00, the count rolls over from FFFFh to 0000h on a tick.
- R7: With `clr_sel` = 2'b01, a tick taken while the count equals `cmp_val` sets the count to 0000h instead of incrementing it. The supported range of `cmp_val` in this mode is 0001h to FFFDh.
- R8: With `clr_sel` = 2'b10, `peer_rst_req` = 1 sets a running count to 0000h on the next clock edge, whatever the prescaler phase. In every other mode `peer_rst_req` is ignored.
- R9: With `clr_sel` = 2'b11, `comm_rst_req` = 1 sets a running count to 0000h on the next clock edge, whatever the prescaler phase. In every other mode `comm_rst_req` is ignored.
- R10: `wr_en` while running loads `wr_data` on the next edge, and counting continues from that value. A write takes priority over a tick on the same edge. A clear request takes priority over a write.
- R11: `wr_en` is ignored while the timer is stopped, including on the edge where it starts. Counting then starts from 0000h.
- R12: `irq_pulse` is high for the single cycle after an edge on which count bit 14 or bit 15 went from 1 to 0. `irq_flag` is set on the following edge and stays set until `irq_clr`. A new pulse wins over `irq_clr` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 5 | Prescaler selector n; 31 means undivided |
| run_local | input | 1 | Local run bit (independent start) |
| run_grp_self | input | 1 | Group run bit for this timer |
| run_grp_peer | input | 1 | Group run bit of the neighbouring timer group |
| clr_sel | input | 2 | Clear source: 00 wrap, 01 match, 10 peer request, 11 communication request |
| cmp_val | input | 16 | Compare value for match clear |
| peer_rst_req | input | 1 | Clear request from the neighbouring group |
| comm_rst_req | input | 1 | Clear request from the communication block |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | 16 | Value to load |
| rd_data | output | 16 | Live count while running, 0000h while stopped |
| irq_pulse | output | 1 | One-cycle bit-14/15 falling-edge pulse |
| irq_flag | output | 1 | Sticky interrupt request |
| irq_clr | input | 1 | Clears `irq_flag` |

## Verification
Each result has a fixed lag. A start shows as an active timer one edge later. The first increment arrives one prescaler period after that. A write or an external clear shows in `rd_data` after one edge. `irq_pulse` appears one cycle after the edge that moved the count, and `irq_flag` one cycle after that. The bench drives all inputs on the falling edge and samples on the falling edge. Its explicit checks count rising edges to land exactly on those cycles. A cycle-level model in the bench is also compared with all three outputs on every falling edge, so that a result arriving one cycle early or late fails.

// File: rtl/bt_pkg.sv
package bt_pkg;

    // Clear-source selector encoding
    typedef enum logic [1:0] {
        CLR_ON_WRAP  = 2'b00,
        CLR_ON_MATCH = 2'b01,
        CLR_ON_PEER  = 2'b10,
        CLR_ON_LINK  = 2'b11
    } clr_src_e;

    // Per-edge control word for the count register, in priority order
    typedef struct packed {
        logic hold;     // timer stopped after this edge
        logic ext_clr;  // external clear request honoured
        logic wr;       // software load while running
        logic tick;     // prescaler tick
        logic wrap;     // tick should produce zero (match)
    } cnt_ctl_t;

    // One-bit falling edge
    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/bt_start_ctl.sv
module bt_start_ctl (
    input  logic clk,
    input  logic rst,
    input  logic run_local,
    input  logic run_grp_self,
    input  logic run_grp_peer,
    output logic active_q,
    output logic active_d
);
    // Start: local bit, or both group bits together.
    // Stop: local bit and own group bit both low.
    always_comb begin
        if (active_q) active_d = run_local | run_grp_self;
        else          active_d = run_local | (run_grp_self & run_grp_peer);
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active_d;
    end
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int               PSC_W      = DIV_W + 1;
    localparam logic [DIV_W-1:0] SEL_BYPASS = '1;

    logic [PSC_W-1:0] pcnt_q;
    logic [PSC_W-1:0] reload;
    logic [DIV_W-1:0] sel_q;
    logic             restart;

    // Period 2(n+1) -> reload 2n+1; bypass -> period 1 -> reload 0
    assign reload  = (div_sel == SEL_BYPASS) ? '0 : {div_sel, 1'b1};
    assign restart = !active || (div_sel != sel_q);
    assign tick    = !restart && (pcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= reload;
            sel_q  <= div_sel;
        end else begin
            sel_q <= div_sel;
            if (restart || tick) pcnt_q <= reload;
            else                 pcnt_q <= pcnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/bt_counter.sv
module bt_counter
    import bt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (ctl.hold)         cnt_d = '0;
        else if (ctl.ext_clr) cnt_d = '0;
        else if (ctl.wr)      cnt_d = wr_data;
        else if (ctl.tick)    cnt_d = ctl.wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bt_irq.sv
module bt_irq
    import bt_pkg::*;
#(
    parameter int NW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] watch,
    input  logic          irq_clr,
    output logic          irq_pulse,
    output logic          irq_flag
);
    logic [NW-1:0] prev_q;
    logic [NW-1:0] fall;

    for (genvar i = 0; i < NW; i++) begin : g_fall
        assign fall[i] = fell(prev_q[i], watch[i]);
    end

    assign irq_pulse = |fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            irq_flag <= 1'b0;
        end else begin
            prev_q   <= watch;
            irq_flag <= (irq_flag & ~irq_clr) | irq_pulse;
        end
    end
endmodule

// File: rtl/bt_timebase.sv
module bt_timebase
    import bt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             run_local,
    input  logic             run_grp_self,
    input  logic             run_grp_peer,
    input  logic [1:0]       clr_sel,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             peer_rst_req,
    input  logic             comm_rst_req,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_pulse,
    output logic             irq_flag,
    input  logic             irq_clr
);
    localparam int IRQ_NW = 2;   // the two top count bits are watched

    logic             active_q;
    logic             active_d;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    clr_src_e         clr_src;
    cnt_ctl_t         ctl;

    assign clr_src = clr_src_e'(clr_sel);

    bt_start_ctl u_start (
        .clk          (clk),
        .rst          (rst),
        .run_local    (run_local),
        .run_grp_self (run_grp_self),
        .run_grp_peer (run_grp_peer),
        .active_q     (active_q),
        .active_d     (active_d)
    );

    bt_prescaler #(.DIV_W(DIV_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .active  (active_q),
        .div_sel (div_sel),
        .tick    (tick)
    );

    always_comb begin
        ctl.hold    = !active_d;
        ctl.ext_clr = ((clr_src == CLR_ON_PEER) && peer_rst_req) ||
                      ((clr_src == CLR_ON_LINK) && comm_rst_req);
        ctl.wr      = active_q && wr_en;
        ctl.tick    = tick;
        ctl.wrap    = (clr_src == CLR_ON_MATCH) && (cnt_q == cmp_val);
    end

    bt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wr_data (wr_data),
        .cnt_q   (cnt_q)
    );

    bt_irq #(.NW(IRQ_NW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .watch     (cnt_q[CNT_W-1 -: IRQ_NW]),
        .irq_clr   (irq_clr),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

    assign rd_data = active_q ? cnt_q : '0;
endmodule

// File: rtl/bt_timebase_chk.sv
module bt_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             active_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             run_local,
    input logic             run_grp_self,
    input logic             run_grp_peer,
    input logic [1:0]       clr_sel,
    input logic             comm_rst_req,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] rd_data,
    input logic             irq_pulse,
    input logic             irq_flag,
    input logic             irq_clr
);
    // R2
    inactive_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> cnt_q == '0);

    // R5
    keep_running_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && (run_local || run_grp_self)) |=> active_q);

    // R4
    no_lone_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !run_local && !(run_grp_self && run_grp_peer)) |=> !active_q);

    // R9
    link_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && run_local && clr_sel == 2'b11 && comm_rst_req) |=> rd_data == '0);

    // R10
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && run_local && wr_en && !clr_sel[1]) |=> rd_data == $past(wr_data));

    // R1
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && run_local && !wr_en && clr_sel == 2'b00) |=>
        (rd_data == $past(rd_data) || rd_data == $past(rd_data) + 1'b1));

    // R12
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> irq_flag);

    // R12
    flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !irq_pulse) |=> !irq_flag);
endmodule

bind bt_timebase bt_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .active_q     (active_q),
    .cnt_q        (cnt_q),
    .run_local    (run_local),
    .run_grp_self (run_grp_self),
    .run_grp_peer (run_grp_peer),
    .clr_sel      (clr_sel),
    .comm_rst_req (comm_rst_req),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .irq_pulse    (irq_pulse),
    .irq_flag     (irq_flag),
    .irq_clr      (irq_clr)
);

// File: tb/bt_timebase_bench.sv
module bt_timebase_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  div_sel = 5'd31;
    logic        run_local = 1'b0, run_grp_self = 1'b0, run_grp_peer = 1'b0;
    logic [1:0]  clr_sel = 2'b00;
    logic [15:0] cmp_val = 16'h0005;
    logic        peer_rst_req = 1'b0, comm_rst_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        irq_pulse, irq_flag;
    logic        irq_clr = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bt_timebase u_bt_timebase (
        .clk(clk), .rst(rst), .div_sel(div_sel), .run_local(run_local),
        .run_grp_self(run_grp_self), .run_grp_peer(run_grp_peer),
        .clr_sel(clr_sel), .cmp_val(cmp_val), .peer_rst_req(peer_rst_req),
        .comm_rst_req(comm_rst_req), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_flag(irq_flag),
        .irq_clr(irq_clr)
    );

    // ---------------- cycle-level reference, written from the requirements
    function automatic int period(input logic [4:0] n);
        return (n == 5'd31) ? 1 : 2 * (int'(n) + 1);
    endfunction

    logic        m_run, m_run_nx, m_tick, m_ext;
    logic [5:0]  m_phase;
    logic [4:0]  m_div;
    logic [15:0] m_cnt, m_prev;
    logic        m_flag;
    logic [15:0] e_rd;
    logic        e_pulse;

    always_comb begin
        m_run_nx = m_run ? (run_local | run_grp_self)
                         : (run_local | (run_grp_self & run_grp_peer));
        m_tick   = m_run && (div_sel == m_div) &&
                   (int'(m_phase) == period(div_sel) - 1);
        m_ext    = (clr_sel == 2'b10 && peer_rst_req) || (clr_sel == 2'b11 && comm_rst_req);
        e_rd     = m_run ? m_cnt : 16'h0000;
        e_pulse  = (m_prev[15] & ~m_cnt[15]) | (m_prev[14] & ~m_cnt[14]);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_run <= 1'b0; m_phase <= 6'd0; m_div <= div_sel;
            m_cnt <= 16'h0000; m_prev <= 16'h0000; m_flag <= 1'b0;
        end else begin
            m_run   <= m_run_nx;
            m_div   <= div_sel;
            m_phase <= (!m_run || div_sel != m_div || m_tick) ? 6'd0 : m_phase + 6'd1;
            m_prev  <= m_cnt;
            m_flag  <= e_pulse | (m_flag & ~irq_clr);
            if (!m_run_nx)          m_cnt <= 16'h0000;
            else if (m_ext)         m_cnt <= 16'h0000;
            else if (wr_en && m_run) m_cnt <= wr_data;
            else if (m_tick)
                m_cnt <= (clr_sel == 2'b01 && m_cnt == cmp_val) ? 16'h0000 : m_cnt + 16'h0001;
        end
    end

    // ---------------- reporting
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic follow(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({tag, " rd_data"}, rd_data, e_rd);
            chk({tag, " irq_pulse"}, {15'd0, irq_pulse}, {15'd0, e_pulse});
            chk({tag, " irq_flag"}, {15'd0, irq_flag}, {15'd0, m_flag});
        end
    endtask

    task automatic stop_all();
        @(negedge clk);
        run_local = 1'b0; run_grp_self = 1'b0; run_grp_peer = 1'b0;
        wr_en = 1'b0; peer_rst_req = 1'b0; comm_rst_req = 1'b0; irq_clr = 1'b0;
        follow(2, "R5 stop");
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual %0d expected below %0d cycles", cyc, WATCHDOG);
            summary();
        end
    end

    // ---------------- scenarios
    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 rd after reset", rd_data, 16'h0000);
        chk("R2 flag after reset", {15'd0, irq_flag}, 16'h0000);
        chk("R2 pulse after reset", {15'd0, irq_pulse}, 16'h0000);
    endtask

    task automatic t_divide(input logic [4:0] n);
        int p;
        stop_all();
        clr_sel = 2'b00; div_sel = n;
        follow(2, "R1 settle");
        p = period(n);
        run_local = 1'b1;                   // R3 independent start
        repeat (p) @(posedge clk);
        @(negedge clk);
        chk("R1 before first tick", rd_data, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        chk("R1 R3 first tick", rd_data, 16'h0001);
        follow(3 * p, "R1 run");
        chk("R1 after four periods", rd_data, 16'h0004);
        run_local = 1'b0;
        @(negedge clk);
        chk("R5 stop clears", rd_data, 16'h0000);
    endtask

    task automatic t_simul();
        stop_all();
        div_sel = 5'd31; clr_sel = 2'b00;
        run_grp_peer = 1'b1;
        follow(3, "R4 peer alone");
        chk("R4 peer alone no start", rd_data, 16'h0000);
        run_grp_peer = 1'b0; run_grp_self = 1'b1;
        follow(3, "R4 self alone");
        chk("R4 self alone no start", rd_data, 16'h0000);
        run_grp_peer = 1'b1;
        follow(4, "R4 both");
        chk("R4 simultaneous start", rd_data, 16'h0003);
        run_grp_peer = 1'b0;
        follow(3, "R5 peer drop");
        chk("R5 peer drop keeps running", rd_data, 16'h0006);
        run_grp_self = 1'b0;
        follow(1, "R5 both low");
        chk("R5 stop when both low", rd_data, 16'h0000);
    endtask

    task automatic t_wrap_irq();
        stop_all();
        div_sel = 5'd31; clr_sel = 2'b00; run_local = 1'b1;
        follow(2, "R10 start");
        wr_en = 1'b1; wr_data = 16'hFFFD;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 load while running", rd_data, 16'hFFFD);
        follow(3, "R6 wrap");
        chk("R6 wrap to zero", rd_data, 16'h0000);
        chk("R12 pulse on bit15 fall", {15'd0, irq_pulse}, 16'h0001);
        follow(1, "R12 flag");
        chk("R12 flag set", {15'd0, irq_flag}, 16'h0001);
        chk("R12 pulse one cycle", {15'd0, irq_pulse}, 16'h0000);
        follow(4, "R12 sticky");
        chk("R12 flag sticky", {15'd0, irq_flag}, 16'h0001);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R12 flag cleared", {15'd0, irq_flag}, 16'h0000);
        wr_en = 1'b1; wr_data = 16'h7FFF;
        @(negedge clk);
        wr_en = 1'b0;
        follow(1, "R12 bit14");
        chk("R12 count after 7FFF", rd_data, 16'h8000);
        chk("R12 pulse on bit14 fall", {15'd0, irq_pulse}, 16'h0001);
        follow(2, "R12 bit14 flag");
        irq_clr = 1'b1;
        follow(1, "R12 clr");
        irq_clr = 1'b0;
        follow(2, "R12 clr done");
    endtask

    task automatic t_match();
        int p;
        stop_all();
        div_sel = 5'd0; clr_sel = 2'b01; cmp_val = 16'h0005;
        follow(1, "R7 settle");
        p = period(5'd0);
        run_local = 1'b1;
        repeat (5 * p + 1) @(posedge clk);
        @(negedge clk);
        chk("R7 reaches compare", rd_data, 16'h0005);
        repeat (p) @(posedge clk);
        @(negedge clk);
        chk("R7 match clears", rd_data, 16'h0000);
        follow(30, "R7 run");
        // upper boundary of the compare range
        div_sel = 5'd31; cmp_val = 16'hFFFD;
        follow(2, "R7 rediv");
        wr_en = 1'b1; wr_data = 16'hFFFB;
        @(negedge clk);
        wr_en = 1'b0;
        follow(2, "R7 top");
        chk("R7 at FFFD", rd_data, 16'hFFFD);
        follow(1, "R7 top clear");
        chk("R7 FFFD match clears", rd_data, 16'h0000);
        follow(4, "R7 after");
    endtask

    task automatic t_external();
        stop_all();
        div_sel = 5'd31; clr_sel = 2'b10; run_local = 1'b1;
        follow(2, "R8 start");
        wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        peer_rst_req = 1'b1;
        @(negedge clk);
        peer_rst_req = 1'b0;
        chk("R8 peer clear", rd_data, 16'h0000);
        clr_sel = 2'b11;
        wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0; peer_rst_req = 1'b1;
        @(negedge clk);
        peer_rst_req = 1'b0;
        chk("R8 peer ignored in mode 11", rd_data, 16'h1235);
        comm_rst_req = 1'b1;
        @(negedge clk);
        comm_rst_req = 1'b0;
        chk("R9 comm clear", rd_data, 16'h0000);
        clr_sel = 2'b10; comm_rst_req = 1'b1;
        @(negedge clk);
        comm_rst_req = 1'b0;
        chk("R9 comm ignored in mode 10", rd_data, 16'h0001);
        // slow prescaler: clear lands on the next edge whatever the phase
        clr_sel = 2'b11; div_sel = 5'd30;
        follow(7, "R9 slow");
        wr_en = 1'b1; wr_data = 16'h4321;
        @(negedge clk);
        wr_en = 1'b0; comm_rst_req = 1'b1;
        @(negedge clk);
        comm_rst_req = 1'b0;
        chk("R9 clear mid-period", rd_data, 16'h0000);
        follow(130, "R1 slow run");
    endtask

    task automatic t_write_stopped();
        stop_all();
        div_sel = 5'd31; clr_sel = 2'b00;
        wr_en = 1'b1; wr_data = 16'h7777;
        @(negedge clk);
        chk("R11 write while stopped", rd_data, 16'h0000);
        run_local = 1'b1;                   // write still high on the start edge
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 start edge write ignored", rd_data, 16'h0000);
        @(negedge clk);
        chk("R11 counts from zero", rd_data, 16'h0001);
        follow(3, "R11 run");
    endtask

    initial begin
        t_reset();
        t_divide(5'd0);
        t_divide(5'd1);
        t_divide(5'd30);
        t_divide(5'd31);
        t_simul();
        t_wrap_irq();
        t_match();
        t_external();
        t_write_stopped();
        stop_all();
        done = 1'b1;
        summary();
    end
endmodule